// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block derives the I2C serial clock (SCL) from the module clock. A programmable prescaler first divides the module clock into ticks, which are meant to fall in the 7 to 12 MHz range. Each SCL period is then one low phase and one high phase. Each phase lasts a programmed tick count plus a fixed offset, and that offset depends only on the prescaler setting. The output is an open-drain pull-down request, so the pad only ever pulls the line low or releases it.

The high phase starts counting only once the synchronized SCL line is seen high. A slave that holds the line low therefore stretches the clock. Divider values are written through a small register port and are captured into working copies at the start of each period, so a write never alters a phase already running. The generator runs only while its enable bit is set and the `master_active` input is high. Otherwise it is held idle with SCL released.

The bit engine receives two single-cycle strobes. `change_stb` marks the middle of the low phase, where new data may be driven. `sample_stb` marks the middle of the high phase, where the line is sampled.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset `scl_drive_low`, `sample_stb` and `change_stb` are all 0, and the generator stays idle until it is enabled.
- R2: The phase offset d is 7 when the prescale value P is 0, 6 when P is 1, and 5 when P is 2 or more.
- R3: The low phase holds `scl_drive_low` at 1 for exactly (P+1)*(L+d) module clock cycles, where L is the low-count value.
- R4: When no slave stretches the clock, the high phase releases the line for exactly (P+1)*(H+d)+SYNC_STAGES cycles, where H is the high-count value.
- R5: High-phase ticks advance only while the synchronized line reads high. Holding the line low for S extra cycles after release delays the rest of the high phase by S cycles.
- R6: `change_stb` is high for one cycle per low phase: the cycle of tick number floor((L+d)/2) of that phase, which is (P+1)*floor((L+d)/2)-1 cycles after `scl_drive_low` rises.
- R7: `sample_stb` is high for one cycle per high phase: the cycle of tick number floor((H+d)/2) of that phase. The two strobes are never high together.
- R8: Register writes change P, L and H only at the start of the next period. The period in progress finishes with the old values.
- R9: While the enable bit is 0 or `master_active` is 0, the line is released from the next cycle on, no strobe fires, and register writes cause no activity. When both become 1 again, the generator restarts with a fresh low phase.
- R10: A write with `wr_en` high selects its target by `wr_sel`: 0 for prescale, 1 for low count, 2 for high count, 3 for control, where control bit 0 is the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | DW | Write data |
| master_active | input | 1 | High while the controller owns the bus as master |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| sample_stb | output | 1 | One-cycle pulse at the middle of the high phase |
| change_stb | output | 1 | One-cycle pulse at the middle of the low phase |

## Verification
Every result is due at a cycle distance fixed by P, L, H and SYNC_STAGES: `change_stb` comes (P+1)*floor((L+d)/2)-1 cycles after the line is pulled low, the release comes after the full low count, and the high-phase strobe and the next pull-down come SYNC_STAGES plus any stretch cycles later. The bench turns each programmed setting into a list of expected events, each with its distance from the previous event. Every observed edge or strobe is compared against the head of that list. Register writes are timed from an observed mid-low strobe, so the period they land in is known and only the following period is expected to change. Stretching is applied at an exact number of cycles after the observed release.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // Fixed extension added to every phase, chosen by the prescale value
  function automatic int unsigned phase_offset(input int unsigned psc);
    if (psc == 0) return 7;
    if (psc == 1) return 6;
    return 5;
  endfunction

  // Phase length in prescaled ticks
  function automatic int unsigned phase_len(input int unsigned cnt, input int unsigned psc);
    return cnt + phase_offset(psc);
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  output logic          gen_en,
  output logic [DW-1:0] psc_s,
  output logic [DW-1:0] low_s,
  output logic [DW-1:0] high_s
);

  logic [DW-1:0] psc_r, low_r, high_r;

  // Programmed values, written at any time (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_r  <= '0;
      low_r  <= '0;
      high_r <= '0;
      gen_en <= 1'b0;
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_PSC:  psc_r  <= wr_data;
        SEL_LOW:  low_r  <= wr_data;
        SEL_HIGH: high_r <= wr_data;
        SEL_CTRL: gen_en <= wr_data[0];
        default:  ;
      endcase
    end
  end

  // Working copies, captured only at a period boundary (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_s  <= '0;
      low_s  <= '0;
      high_s <= '0;
    end else if (load) begin
      psc_s  <= psc_r;
      low_s  <= low_r;
      high_s <= high_r;
    end
  end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign line_q = line_in;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh <= '1;
        end else begin
          sh[0] <= line_in;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign line_q = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [DW-1:0] limit,
  output logic          tick
);

  logic [DW-1:0] pcnt;

  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clear)  pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else if (run)    pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          line_high,
  input  logic          tick,
  input  logic [DW-1:0] psc_s,
  input  logic [DW-1:0] low_s,
  input  logic [DW-1:0] high_s,
  output logic          run,
  output logic          idle,
  output logic          load,
  output logic          drive_low,
  output logic          change_stb,
  output logic          sample_stb
);

  localparam int CW = DW + 1;

  phase_e        state;
  logic [CW-1:0] ph_cnt;
  logic [CW-1:0] len_lo, len_hi;
  logic [CW-1:0] mid_lo, mid_hi;
  logic          end_lo, end_hi;

  assign len_lo = CW'(phase_len(32'(low_s), 32'(psc_s)));
  assign len_hi = CW'(phase_len(32'(high_s), 32'(psc_s)));
  assign mid_lo = (len_lo >> 1) - CW'(1);
  assign mid_hi = (len_hi >> 1) - CW'(1);

  // High-phase ticks need the line actually high (R5)
  assign run  = active && ((state == PH_LOW) || ((state == PH_HIGH) && line_high));
  assign idle = (state == PH_IDLE);

  assign end_lo = (state == PH_LOW)  && tick && (ph_cnt == len_lo - CW'(1));
  assign end_hi = (state == PH_HIGH) && tick && (ph_cnt == len_hi - CW'(1));
  assign load   = idle || end_hi;

  assign drive_low  = (state == PH_LOW);
  assign change_stb = (state == PH_LOW)  && tick && (ph_cnt == mid_lo);
  assign sample_stb = (state == PH_HIGH) && tick && (ph_cnt == mid_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      ph_cnt <= '0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          ph_cnt <= '0;
          if (active) state <= PH_LOW;
        end
        PH_LOW: begin
          if (!active) begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
          end else if (end_lo) begin
            state  <= PH_HIGH;
            ph_cnt <= '0;
          end else if (tick) begin
            ph_cnt <= ph_cnt + CW'(1);
          end
        end
        PH_HIGH: begin
          if (!active) begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
          end else if (end_hi) begin
            state  <= PH_LOW;
            ph_cnt <= '0;
          end else if (tick) begin
            ph_cnt <= ph_cnt + CW'(1);
          end
        end
        default: begin
          state  <= PH_IDLE;
          ph_cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          master_active,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          sample_stb,
  output logic          change_stb
);

  logic          gen_en;
  logic          active_w;
  logic          line_high;
  logic          tick;
  logic          run;
  logic          idle;
  logic          load;
  logic [DW-1:0] psc_s, low_s, high_s;

  assign active_w = gen_en && master_active;

  scl_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(load), .gen_en(gen_en), .psc_s(psc_s), .low_s(low_s), .high_s(high_s)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(line_high)
  );

  scl_prescaler #(.DW(DW)) u_psc (
    .clk(clk), .rst_n(rst_n), .clear(idle), .run(run), .limit(psc_s), .tick(tick)
  );

  scl_phase_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active_w), .line_high(line_high), .tick(tick),
    .psc_s(psc_s), .low_s(low_s), .high_s(high_s),
    .run(run), .idle(idle), .load(load), .drive_low(scl_drive_low),
    .change_stb(change_stb), .sample_stb(sample_stb)
  );

endmodule

// File: rtl/scl_clock_gen_checks.sv
module scl_clock_gen_checks #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          line_high,
  input logic          tick,
  input logic          load,
  input logic [DW-1:0] psc_s,
  input logic [DW-1:0] low_s,
  input logic [DW-1:0] high_s,
  input logic          drive_low,
  input logic          sample_stb,
  input logic          change_stb
);

  assert_no_tick_while_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_high && !drive_low) |-> !tick);

  assert_dividers_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(psc_s) && $stable(low_s) && $stable(high_s)));

  assert_period_starts_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(load));

  assert_release_when_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !drive_low);

  assert_quiet_when_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sample_stb && !change_stb));

  assert_change_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |-> drive_low);

  assert_sample_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!drive_low && line_high));

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, change_stb}));

endmodule

bind scl_clock_gen scl_clock_gen_checks #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active_w), .line_high(line_high), .tick(tick),
  .load(load), .psc_s(psc_s), .low_s(low_s), .high_s(high_s),
  .drive_low(scl_drive_low), .sample_stb(sample_stb), .change_stb(change_stb)
);

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  localparam int DW = 16;
  localparam int NS = 2;  // synchronizer depth
  localparam int EV_CHG = 0, EV_FALL = 1, EV_SAMP = 2, EV_RISE = 3;

  typedef struct {
    int    kind;
    int    delta;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic          master_active = 1'b0;
  logic          stretch = 1'b0;
  logic          scl_in;
  logic          scl_drive_low, sample_stb, change_stb;

  assign scl_in = !(scl_drive_low || stretch);

  scl_clock_gen #(.DW(DW), .SYNC_STAGES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .master_active(master_active), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sample_stb(sample_stb), .change_stb(change_stb)
  );

  always #5 clk = ~clk;

  item_t exp_q[$];
  int    checks = 0, fails = 0;
  int    cyc = 0, last = 0;
  int    chg_cnt = 0, fall_cnt = 0, ev_total = 0;
  bit    anchor_wait = 0, mute = 0;
  logic  prev_drive = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected events for one SCL period (d per R2)
  task automatic push_period(input int p, input int l, input int h, input int s, input string why);
    int d, lo, hi, hl, hh;
    d  = (p >= 2) ? 5 : 7 - p;   // R2
    lo = l + d;
    hi = h + d;
    hl = lo / 2;
    hh = hi / 2;
    exp_q.push_back('{EV_CHG,  (p+1)*hl - 1,            {"R6 R2 ", why}});
    exp_q.push_back('{EV_FALL, (p+1)*lo - (p+1)*hl + 1, {"R3 R2 ", why}});
    exp_q.push_back('{EV_SAMP, NS + s + (p+1)*hh - 1,   {(s != 0) ? "R5 " : "R7 ", why}});
    exp_q.push_back('{EV_RISE, (p+1)*hi - (p+1)*hh + 1, {"R4 R2 ", why}});
  endtask

  // Register port: 0 prescale, 1 low, 2 high, 3 control (R10)
  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = DW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_div(input int p, input int l, input int h);
    wr(2'd0, p);
    wr(2'd1, l);
    wr(2'd2, h);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic note(input int kind);
    item_t it;
    ev_total++;
    if (kind == EV_CHG)  chg_cnt++;
    if (kind == EV_FALL) fall_cnt++;
    if (anchor_wait && kind == EV_RISE) begin
      anchor_wait = 0;
      last = cyc;
    end else if (mute) begin
      last = cyc;
    end else if (exp_q.size() == 0) begin
      check(0, "R9 unexpected event", kind, -1);
      last = cyc;
    end else begin
      it = exp_q.pop_front();
      check(it.kind == kind, {it.tag, " kind"}, kind, it.kind);
      check((cyc - last) == it.delta, {it.tag, " spacing"}, cyc - last, it.delta);
      last = cyc;
    end
  endtask

  // Monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_drive_low && !prev_drive) note(EV_RISE);
      if (!scl_drive_low && prev_drive) note(EV_FALL);
      if (change_stb) note(EV_CHG);
      if (sample_stb) note(EV_SAMP);
    end
    prev_drive = scl_drive_low;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, base;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b0, "R1 drive after reset", int'(scl_drive_low), 0);
    check(sample_stb == 1'b0, "R1 sample after reset", int'(sample_stb), 0);
    check(change_stb == 1'b0, "R1 change after reset", int'(change_stb), 0);

    // Setting A: P=0 (d=7)
    master_active = 1'b1;
    wr_div(0, 2, 3);
    anchor_wait = 1;
    push_period(0, 2, 3, 0, "A");
    push_period(0, 2, 3, 0, "A");
    wr(2'd3, 1);
    drain();

    // R8: write B mid-period, current period stays A
    push_period(0, 2, 3, 0, "R8 old");
    push_period(1, 0, 1, 0, "R8 R10 B");
    push_period(1, 0, 1, 0, "R8 R10 B");
    n = chg_cnt;
    wait (chg_cnt > n);
    wr_div(1, 0, 1);
    drain();

    // Setting C: P=2 (d=5), second period stretched by 6 (R5)
    push_period(1, 0, 1, 0, "R8 old");
    push_period(2, 1, 0, 0, "C");
    push_period(2, 1, 0, 6, "C stretch");
    n = chg_cnt;
    wait (chg_cnt > n);
    wr_div(2, 1, 0);
    n = chg_cnt;
    wait (chg_cnt > n);
    n = chg_cnt;
    wait (chg_cnt > n);
    stretch = 1'b1;
    n = fall_cnt;
    wait (fall_cnt > n);
    repeat (6) @(negedge clk);
    stretch = 1'b0;
    drain();

    // Setting D: P=3, zero counts (phase length = d), stretch 3
    push_period(2, 1, 0, 0, "R8 old");
    push_period(3, 0, 0, 0, "D");
    push_period(3, 0, 0, 3, "D stretch");
    n = chg_cnt;
    wait (chg_cnt > n);
    wr_div(3, 0, 0);
    n = chg_cnt;
    wait (chg_cnt > n);
    n = chg_cnt;
    wait (chg_cnt > n);
    stretch = 1'b1;
    n = fall_cnt;
    wait (fall_cnt > n);
    repeat (3) @(negedge clk);
    stretch = 1'b0;
    drain();

    // R9: disabled generator ignores writes and master toggles
    mute = 1;
    wr(2'd3, 0);
    repeat (5) @(negedge clk);
    check(scl_drive_low == 1'b0, "R9 released after disable", int'(scl_drive_low), 0);
    mute = 0;
    base = ev_total;
    wr_div(0, 1, 1);
    master_active = 1'b0;
    repeat (3) @(negedge clk);
    master_active = 1'b1;
    repeat (30) @(negedge clk);
    check(ev_total == base, "R9 events while disabled", ev_total - base, 0);
    check(scl_drive_low == 1'b0, "R9 drive while disabled", int'(scl_drive_low), 0);

    // R9: enabled but not master
    master_active = 1'b0;
    wr(2'd3, 1);
    repeat (30) @(negedge clk);
    check(ev_total == base, "R9 events without master", ev_total - base, 0);
    check(scl_drive_low == 1'b0, "R9 drive without master", int'(scl_drive_low), 0);

    // R9: restart with a fresh low phase
    anchor_wait = 1;
    push_period(0, 1, 1, 0, "R9 restart");
    push_period(0, 1, 1, 0, "R9 restart");
    master_active = 1'b1;
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule